// File: doc/BRIEF.md
# Radio Command Strobe State Controller

This block is the main control state machine of a simple packet radio. A CPU writes one-byte command strobes. The controller moves between five states: idle, synthesizer calibration, a synthesizer-only wait state, receive and transmit. It drives the synthesizer, receiver and transmitter enables to match the current state. Two configuration inputs shape the transitions. One bit makes the block calibrate automatically whenever it leaves idle. The other bit, together with a channel-clear flag from the demodulator, gates the switch from receive to transmit.

Calibration is modelled as a counter that runs for a fixed, parameterised number of cycles and then raises a done pulse. When the pulse arrives, the controller enters the state that was requested when calibration began. A strobe written during calibration is held and carried out after calibration ends. An idle strobe is the exception: it cancels calibration at once. The analog synthesizer, the modem datapath, packet handling and register mapping are all outside this block.

Top module: `radio_strobe_ctrl`

## Requirements
- R1: After reset, `state_o` is idle (encoding 0) and `synth_en`, `rx_en` and `tx_en` are all low. The state encodings are idle 0, calibrating 1, synthesizer-only wait 2, receive 3 and transmit 4.
- R2: With `strobe_valid` high, `strobe_code` 0x00 means synthesizer-on, 0x01 calibrate, 0x02 receive, 0x03 transmit and 0x04 idle. Any other code is a no-operation and leaves the state unchanged.
- R3: A calibrate strobe in idle enters calibration whatever `autocal_en` holds. The block stays in calibration for exactly CAL_CYCLES cycles and then returns to idle.
- R4: A receive or transmit strobe in idle enters calibration when `autocal_en` is 1. It then reaches receive or transmit after exactly CAL_CYCLES cycles. When `autocal_en` is 0, the block goes straight to the target state on the next cycle.
- R5: A synthesizer-on strobe in idle reaches the wait state, calibrating first when `autocal_en` is 1. In the wait state only `synth_en` is high.
- R6: In receive, a transmit strobe with `cca_en` high moves to transmit only if `chan_clear` is high; otherwise the block stays in receive. With `cca_en` low, the transmit strobe always moves to transmit.
- R7: An idle strobe moves to idle on the next cycle from every state, including calibration, which it cancels.
- R8: A non-idle strobe received during calibration is latched, and a later one replaces an earlier one. The latched strobe is acted on in the first cycle after calibration reaches its target. An idle strobe during calibration discards the latched strobe.
- R9: Receive and transmit strobes in the wait state go directly to receive or transmit on the next cycle, with no calibration.
- R10: `synth_en` is high in every state except idle, `rx_en` is high only in receive, and `tx_en` is high only in transmit.
- R11: A calibrate strobe outside idle has no effect; for example, receive stays in receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_valid | input | 1 | Qualifies `strobe_code` for one cycle |
| strobe_code | input | 8 | Command strobe byte |
| autocal_en | input | 1 | Calibrate automatically when leaving idle |
| cca_en | input | 1 | Gate receive-to-transmit on channel clear |
| chan_clear | input | 1 | Channel-clear flag from the demodulator |
| state_o | output | 3 | Current state encoding |
| synth_en | output | 1 | Synthesizer enable |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |

## Verification
The bench measures the length of every calibration cycle by cycle. A counter that is off by one would show a calibration one cycle too long or too short. It blocks a transmit strobe in receive with a busy channel, where a design that ignored clear-channel assessment would start transmitting. It sends strobes during calibration and expects the most recent one to be carried out exactly one cycle after the target is reached. A design that dropped latched strobes, or kept them after an idle cancel, would land in the wrong state. It also cancels calibration with an idle strobe and then waits past the calibration length: a counter left running would later push the block out of idle on its own.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CAL  = 3'd1,
    ST_FSON = 3'd2,
    ST_RX   = 3'd3,
    ST_TX   = 3'd4
  } rsc_state_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_FSON,
    CMD_CAL,
    CMD_RX,
    CMD_TX,
    CMD_IDLE
  } rsc_cmd_e;

  // Map a qualified strobe byte onto an internal command.
  function automatic rsc_cmd_e decode_strobe(input logic valid, input logic [7:0] code);
    rsc_cmd_e c;
    c = CMD_NONE;
    if (valid) begin
      case (code)
        8'h00:   c = CMD_FSON;
        8'h01:   c = CMD_CAL;
        8'h02:   c = CMD_RX;
        8'h03:   c = CMD_TX;
        8'h04:   c = CMD_IDLE;
        default: c = CMD_NONE;
      endcase
    end
    return c;
  endfunction

  // Transmit from receive is allowed unless clear-channel gating blocks it.
  function automatic logic tx_permitted(input logic cca_on, input logic clear);
    return !cca_on || clear;
  endfunction
endpackage

// File: rtl/rsc_cal_timer.sv
module rsc_cal_timer #(
  parameter int CAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
    else                   cnt <= '0;
  end
endmodule

// File: rtl/rsc_next_state.sv
module rsc_next_state
  import rsc_pkg::*;
(
  input  rsc_state_e state,
  input  rsc_cmd_e   cmd,
  input  logic       autocal_en,
  input  logic       cca_en,
  input  logic       chan_clear,
  input  logic       cal_done,
  input  rsc_state_e cal_target,
  output rsc_state_e next_state,
  output rsc_state_e next_target
);
  // Leave idle toward dest, calibrating first when asked to.
  function automatic rsc_state_e from_idle(input logic ac, input rsc_state_e dest);
    return ac ? ST_CAL : dest;
  endfunction

  always_comb begin
    next_state  = state;
    next_target = cal_target;
    case (state)
      ST_IDLE: begin
        case (cmd)
          CMD_FSON: begin next_state = from_idle(autocal_en, ST_FSON); next_target = ST_FSON; end
          CMD_RX:   begin next_state = from_idle(autocal_en, ST_RX);   next_target = ST_RX;   end
          CMD_TX:   begin next_state = from_idle(autocal_en, ST_TX);   next_target = ST_TX;   end
          CMD_CAL:  begin next_state = ST_CAL;                          next_target = ST_IDLE; end
          default:  ;
        endcase
      end
      ST_CAL: begin
        if (cmd == CMD_IDLE) next_state = ST_IDLE;
        else if (cal_done)   next_state = cal_target;
      end
      ST_FSON: begin
        case (cmd)
          CMD_RX:   next_state = ST_RX;
          CMD_TX:   next_state = ST_TX;
          CMD_IDLE: next_state = ST_IDLE;
          default:  ;
        endcase
      end
      ST_RX: begin
        case (cmd)
          CMD_TX:   if (tx_permitted(cca_en, chan_clear)) next_state = ST_TX;
          CMD_FSON: next_state = ST_FSON;
          CMD_IDLE: next_state = ST_IDLE;
          default:  ;
        endcase
      end
      ST_TX: begin
        case (cmd)
          CMD_RX:   next_state = ST_RX;
          CMD_FSON: next_state = ST_FSON;
          CMD_IDLE: next_state = ST_IDLE;
          default:  ;
        endcase
      end
      default: next_state = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/rsc_out_map.sv
module rsc_out_map
  import rsc_pkg::*;
(
  input  rsc_state_e state,
  output logic       synth_en,
  output logic       rx_en,
  output logic       tx_en
);
  always_comb begin
    synth_en = 1'b0;
    rx_en    = 1'b0;
    tx_en    = 1'b0;
    case (state)
      ST_CAL, ST_FSON: synth_en = 1'b1;
      ST_RX:   begin synth_en = 1'b1; rx_en = 1'b1; end
      ST_TX:   begin synth_en = 1'b1; tx_en = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/radio_strobe_ctrl.sv
module radio_strobe_ctrl
  import rsc_pkg::*;
#(
  parameter int CAL_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_valid,
  input  logic [7:0] strobe_code,
  input  logic       autocal_en,
  input  logic       cca_en,
  input  logic       chan_clear,
  output logic [2:0] state_o,
  output logic       synth_en,
  output logic       rx_en,
  output logic       tx_en
);
  rsc_state_e state, next_state, cal_target, next_target;
  rsc_cmd_e   cmd_in, eff_cmd, pend_cmd;
  logic       pend_v;
  logic       cal_done;
  logic       in_cal;

  assign in_cal = (state == ST_CAL);
  assign cmd_in = decode_strobe(strobe_valid, strobe_code);

  // A strobe latched during calibration is replayed once calibration ends; a fresh one wins.
  assign eff_cmd = (!in_cal && pend_v && cmd_in == CMD_NONE) ? pend_cmd : cmd_in;

  rsc_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_cal),
    .done  (cal_done)
  );

  rsc_next_state u_next (
    .state       (state),
    .cmd         (eff_cmd),
    .autocal_en  (autocal_en),
    .cca_en      (cca_en),
    .chan_clear  (chan_clear),
    .cal_done    (cal_done),
    .cal_target  (cal_target),
    .next_state  (next_state),
    .next_target (next_target)
  );

  rsc_out_map u_out (
    .state    (state),
    .synth_en (synth_en),
    .rx_en    (rx_en),
    .tx_en    (tx_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cal_target <= ST_IDLE;
    end else begin
      state      <= next_state;
      cal_target <= next_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_cmd <= CMD_NONE;
    end else if (in_cal) begin
      if (cmd_in == CMD_IDLE) begin
        pend_v <= 1'b0;
      end else if (cmd_in != CMD_NONE) begin
        pend_v   <= 1'b1;
        pend_cmd <= cmd_in;
      end
    end else begin
      pend_v <= 1'b0;
    end
  end

  assign state_o = state;
endmodule

// File: rtl/radio_strobe_ctrl_checker.sv
module radio_strobe_ctrl_checker
  import rsc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       strobe_valid,
  input logic [7:0] strobe_code,
  input logic       cca_en,
  input logic       chan_clear,
  input logic [2:0] state_o,
  input logic       synth_en,
  input logic       rx_en,
  input logic       tx_en,
  input logic       cal_done
);
  logic idle_strobe;
  assign idle_strobe = strobe_valid && (strobe_code == 8'h04);

  AST_IDLE_FROM_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    idle_strobe |=> (state_o == ST_IDLE)); // R7

  AST_CCA_HOLDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RX && strobe_valid && strobe_code == 8'h03 && cca_en && !chan_clear)
    |=> (state_o == ST_RX)); // R6

  AST_CAL_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_CAL && !cal_done && !idle_strobe) |=> (state_o == ST_CAL)); // R3

  AST_CAL_DONE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !idle_strobe) |=> (state_o != ST_CAL)); // R4

  AST_WAIT_TO_RX_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_FSON && strobe_valid && strobe_code == 8'h02) |=> (state_o == ST_RX)); // R9

  AST_RX_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && tx_en)); // R10

  AST_SYNTH_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != ST_IDLE) |-> synth_en); // R10
endmodule

bind radio_strobe_ctrl radio_strobe_ctrl_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strobe_valid (strobe_valid),
  .strobe_code  (strobe_code),
  .cca_en       (cca_en),
  .chan_clear   (chan_clear),
  .state_o      (state_o),
  .synth_en     (synth_en),
  .rx_en        (rx_en),
  .tx_en        (tx_en),
  .cal_done     (cal_done)
);

// File: tb/radio_strobe_ctrl_test.sv
module radio_strobe_ctrl_test;
  localparam int CAL_N = 16;
  localparam int S_IDLE = 0, S_CAL = 1, S_FSON = 2, S_RX = 3, S_TX = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_valid = 1'b0;
  logic [7:0] strobe_code = 8'h00;
  logic       autocal_en = 1'b0;
  logic       cca_en = 1'b0;
  logic       chan_clear = 1'b0;
  logic [2:0] state_o;
  logic       synth_en, rx_en, tx_en;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  radio_strobe_ctrl #(.CAL_CYCLES(CAL_N)) uut (
    .clk(clk), .rst_n(rst_n), .strobe_valid(strobe_valid), .strobe_code(strobe_code),
    .autocal_en(autocal_en), .cca_en(cca_en), .chan_clear(chan_clear),
    .state_o(state_o), .synth_en(synth_en), .rx_en(rx_en), .tx_en(tx_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // State plus enables as the outputs should show them for that state.
  task automatic expect_state(input int exp, input string req);
    check(int'(state_o) == exp, req, int'(state_o), exp);
    check(synth_en == (exp != S_IDLE), {req, "/synth"}, int'(synth_en), int'(exp != S_IDLE));
    check(rx_en == (exp == S_RX), {req, "/rx"}, int'(rx_en), int'(exp == S_RX));
    check(tx_en == (exp == S_TX), {req, "/tx"}, int'(tx_en), int'(exp == S_TX));
  endtask

  // Drive one strobe for one cycle; returns at the negedge after the capturing edge.
  task automatic strobe(input logic [7:0] code);
    @(negedge clk);
    strobe_valid = 1'b1;
    strobe_code  = code;
    @(negedge clk);
    strobe_valid = 1'b0;
  endtask

  task automatic cal_length(output int n);
    n = 0;
    while (int'(state_o) == S_CAL && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic go_idle();
    strobe(8'h04);
  endtask

  task automatic t_reset();
    expect_state(S_IDLE, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    expect_state(S_IDLE, "R1");
  endtask

  task automatic t_nop_codes();
    strobe(8'h05); expect_state(S_IDLE, "R2");
    strobe(8'hFF); expect_state(S_IDLE, "R2");
    autocal_en = 1'b0;
    strobe(8'h02); expect_state(S_RX, "R2");
    strobe(8'h80); expect_state(S_RX, "R2");
    go_idle();
  endtask

  task automatic t_cal_only();
    int n;
    autocal_en = 1'b0;
    strobe(8'h01);
    expect_state(S_CAL, "R3");
    cal_length(n);
    check(n == CAL_N, "R3", n, CAL_N);
    expect_state(S_IDLE, "R3");
  endtask

  task automatic t_leave_idle();
    int n;
    autocal_en = 1'b1;
    strobe(8'h02);
    cal_length(n);
    check(n == CAL_N, "R4", n, CAL_N);
    expect_state(S_RX, "R4");
    go_idle();
    strobe(8'h03);
    cal_length(n);
    check(n == CAL_N, "R4", n, CAL_N);
    expect_state(S_TX, "R4");
    go_idle();
    autocal_en = 1'b0;
    strobe(8'h03);
    expect_state(S_TX, "R4");
    go_idle();
    expect_state(S_IDLE, "R7");
  endtask

  task automatic t_fson();
    int n;
    autocal_en = 1'b1;
    strobe(8'h00);
    cal_length(n);
    check(n == CAL_N, "R5", n, CAL_N);
    expect_state(S_FSON, "R5");
    strobe(8'h03);
    expect_state(S_TX, "R9");
    strobe(8'h00);
    expect_state(S_FSON, "R5");
    strobe(8'h02);
    expect_state(S_RX, "R9");
    strobe(8'h00);
    go_idle();
    autocal_en = 1'b0;
    strobe(8'h00);
    expect_state(S_FSON, "R5");
    go_idle();
  endtask

  task automatic t_cca();
    autocal_en = 1'b0;
    strobe(8'h02);
    cca_en = 1'b1; chan_clear = 1'b0;
    strobe(8'h03);
    expect_state(S_RX, "R6");
    chan_clear = 1'b1;
    strobe(8'h03);
    expect_state(S_TX, "R6");
    strobe(8'h02);
    expect_state(S_RX, "R6");
    cca_en = 1'b0; chan_clear = 1'b0;
    strobe(8'h03);
    expect_state(S_TX, "R6");
    go_idle();
  endtask

  task automatic t_cal_ignored();
    autocal_en = 1'b0;
    strobe(8'h02);
    strobe(8'h01);
    expect_state(S_RX, "R11");
    repeat (CAL_N + 2) @(negedge clk);
    expect_state(S_RX, "R11");
    go_idle();
  endtask

  task automatic t_idle_abort();
    autocal_en = 1'b1;
    strobe(8'h02);
    repeat (3) @(negedge clk);
    strobe(8'h04);
    expect_state(S_IDLE, "R7");
    repeat (CAL_N + 2) @(negedge clk);
    expect_state(S_IDLE, "R7");
    strobe(8'h00);
    strobe(8'h02);
    strobe(8'h04);
    repeat (CAL_N + 2) @(negedge clk);
    expect_state(S_IDLE, "R8");
  endtask

  task automatic t_pending();
    autocal_en = 1'b1;
    strobe(8'h00);
    strobe(8'h02);
    strobe(8'h03);
    while (int'(state_o) == S_CAL) @(negedge clk);
    expect_state(S_FSON, "R8");
    @(negedge clk);
    expect_state(S_TX, "R8");
    @(negedge clk);
    expect_state(S_TX, "R8");
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_nop_codes();
    t_cal_only();
    t_leave_idle();
    t_fson();
    t_cca();
    t_cal_ignored();
    t_idle_abort();
    t_pending();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule